// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Mode and Rewind

This block is a first-in first-out buffer between two unrelated clocks. It has a 9-bit data path and a parameterised depth. The writer pushes words on its own clock. The reader takes them on a second clock. The pointers cross between the two clock domains as Gray code through synchroniser stages.

The read side runs in one of two modes, and the mode is captured while master reset is held. In standard mode the reader asks for every word with a read strobe, and `no_data` acts as an empty flag. In fall-through mode the oldest word is placed on `dout` without any request. In that mode `no_data` low means the word shown on `dout` is valid, and a read strobe consumes that word. A partial reset empties the buffer and keeps the captured mode.

A rewind request moves the read pointer back to memory location zero, so that the words written since the last reset can be read again. While the rewind is being set up, the block reports that no data is available.

Top module: `fifo_top`

## Requirements
- R1: The read mode is taken from `mode_sel` on the read-clock edges that occur while `mrst` is high: 0 selects standard mode and 1 selects fall-through mode. After `mrst` falls, changes on `mode_sel` have no effect.
- R2: While `mrst` or `prst` is high, both pointers return to location 0, `dout` is cleared to zero, `no_data` is 1 and `no_room` is 0.
- R3: A partial reset keeps the read mode that was active before it, whatever the level of `mode_sel`.
- R4: In standard mode, `dout` changes only on a read-clock edge at which `re` is 1 and `no_data` is 0. On that edge `dout` takes the oldest unread word, and words leave in the order they were written.
- R5: In fall-through mode, a word written into an empty buffer is on `dout`, with `no_data` at 0, after the third read-clock rising edge that follows its write edge. No `re` is needed. Each `re` taken while `no_data` is 0 replaces that word with the next one, or sets `no_data` to 1 if no word remains.
- R6: In standard mode, `no_data` falls on the third read-clock rising edge after the write edge of the first word put into an empty buffer.
- R7: `no_room` is 1 right after the write edge that stores the DEPTH-th unread word. A write while `no_room` is 1 is dropped. In standard mode a read while `no_data` is 1 is dropped, and neither case moves a pointer.
- R8: A rewind starts when `retx` is 1 on a read-clock edge while no rewind is pending. `re` and `we` must be 0 at that time. The read pointer goes back to 0, and `no_data` is 1 after that edge and after the next one, then is released on the second edge after it. In standard mode, `dout` stays unchanged until a later `re` reads location 0.
- R9: In fall-through mode, at the edge where a rewind releases `no_data`, `dout` already holds the word at location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Write clock |
| clk_r | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, asynchronous; mode captured while high |
| prst | input | 1 | Partial reset, active high, asynchronous; keeps the mode |
| mode_sel | input | 1 | Read mode choice sampled during master reset (0 standard, 1 fall-through) |
| we | input | 1 | Write enable, sampled on clk_w |
| din | input | 9 | Write data |
| re | input | 1 | Read enable, sampled on clk_r |
| retx | input | 1 | Rewind request, sampled on clk_r |
| dout | output | 9 | Read data register |
| no_data | output | 1 | Standard: buffer empty. Fall-through: dout not valid |
| no_room | output | 1 | Buffer holds DEPTH unread words |

## Verification
The timing of each result is fixed:
- `no_room` answers on the same write edge that fills the last slot.
- A standard read updates `dout` on the read edge that takes the strobe.
- A word written into an empty buffer becomes visible on the read side on the third read edge after its write edge.
- A rewind keeps `no_data` high for two edges and releases it on the second edge after the request.

The bench counts read-clock edges from the exact edge at which each strobe was sampled. Strobes are dropped with non-blocking assignments at that edge. Outputs are sampled 1 ns after the counted edge, and the clock phases are chosen so that the edges of the two clocks never coincide. The "not yet" state one edge early and the "done" state on the due edge are both checked.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a Gray-coded pointer.
module fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or posedge rst) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge rst) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_dpram.sv
`timescale 1ns/1ps
// Simple dual-port memory: write port on clk_w, registered read port on clk_r.
module fifo_dpram #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          clk_w,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          clk_r,
  input  logic          rst,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_w) begin
    if (wen) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk_r or posedge rst) begin
    if (rst)      rdata <= '0;
    else if (ren) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_wr_ctrl.sv
`timescale 1ns/1ps
// Write pointer, Gray conversion and full flag (write clock domain).
module fifo_wr_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk_w,
  input  logic          rst,
  input  logic          we,
  input  logic [AW:0]   rgray_s,
  output logic          mem_we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          full
);
  logic          accept;
  logic [AW:0]   wbin_nxt;
  logic [AW:0]   wgray_nxt;
  logic [AW:0]   rgray_wrap;

  assign accept     = we & ~full;
  assign wbin_nxt   = wbin + {{AW{1'b0}}, accept};
  assign wgray_nxt  = wbin_nxt ^ (wbin_nxt >> 1);
  // Full when the write pointer is one lap ahead: top two Gray bits inverted.
  assign rgray_wrap = {~rgray_s[AW -: 2], rgray_s[AW-2:0]};

  always_ff @(posedge clk_w or posedge rst) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wgray_nxt;
      full  <= (wgray_nxt == rgray_wrap);
    end
  end

  assign mem_we = accept;
  assign waddr  = wbin[AW-1:0];
endmodule

// File: rtl/fifo_rd_ctrl.sv
`timescale 1ns/1ps
// Read pointer, read-mode latch, rewind sequencer and no-data flag (read clock domain).
module fifo_rd_ctrl
  import fifo_pkg::*;
#(
  parameter int AW        = 4,
  parameter int RT_CYCLES = 2
) (
  input  logic          clk_r,
  input  logic          rst,
  input  logic          mrst,
  input  logic          mode_sel,
  input  logic          re,
  input  logic          retx,
  input  logic [AW:0]   wgray_s,
  output logic          mem_rd,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          no_data,
  output logic          fwft_on,
  output logic          rt_idle
);
  localparam int CW = $clog2(RT_CYCLES + 1);

  rd_mode_e      mode_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [AW:0]   rbin_nxt;
  logic          nd_q, nd_nxt;
  logic          rd_en;
  logic          has_word;
  logic          rt_go;

  // Mode is captured only while master reset is held; partial reset leaves it.
  always_ff @(posedge clk_r) begin
    if (mrst) mode_q <= mode_sel ? MODE_FWFT : MODE_STD;
  end

  assign has_word = (rgray != wgray_s);
  assign rt_go    = retx && (cnt_q == '0);

  always_comb begin
    rbin_nxt = rbin;
    cnt_nxt  = cnt_q;
    nd_nxt   = nd_q;
    rd_en    = 1'b0;
    if (rt_go) begin
      rbin_nxt = '0;
      cnt_nxt  = CW'(RT_CYCLES);
      nd_nxt   = 1'b1;
    end else if (cnt_q > CW'(1)) begin
      cnt_nxt = cnt_q - CW'(1);
      nd_nxt  = 1'b1;
    end else begin
      cnt_nxt = '0;
      if (mode_q == MODE_STD) begin
        rd_en    = re && !nd_q;
        rbin_nxt = rbin + {{AW{1'b0}}, rd_en};
        nd_nxt   = ((rbin_nxt ^ (rbin_nxt >> 1)) == wgray_s);
      end else begin
        rd_en    = has_word && (nd_q || re);
        rbin_nxt = rbin + {{AW{1'b0}}, rd_en};
        if (rd_en)   nd_nxt = 1'b0;
        else if (re) nd_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_r or posedge rst) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      cnt_q <= '0;
      nd_q  <= 1'b1;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      cnt_q <= cnt_nxt;
      nd_q  <= nd_nxt;
    end
  end

  assign mem_rd  = rd_en;
  assign raddr   = rbin[AW-1:0];
  assign no_data = nd_q;
  assign fwft_on = (mode_q == MODE_FWFT);
  assign rt_idle = (cnt_q == '0);
endmodule

// File: rtl/fifo_top.sv
`timescale 1ns/1ps
module fifo_top #(
  parameter int DW          = 9,
  parameter int DEPTH       = 16,
  parameter int RT_CYCLES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_w,
  input  logic          clk_r,
  input  logic          mrst,
  input  logic          prst,
  input  logic          mode_sel,
  input  logic          we,
  input  logic [DW-1:0] din,
  input  logic          re,
  input  logic          retx,
  output logic [DW-1:0] dout,
  output logic          no_data,
  output logic          no_room
);
  localparam int AW = $clog2(DEPTH);

  logic          rst_any;
  logic          mem_we, mem_rd;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wbin, wgray, rbin, rgray;
  logic [AW:0]   wgray_s, rgray_s;
  logic          fwft_on, rt_idle;

  assign rst_any = mrst | prst;

  fifo_wr_ctrl #(.AW(AW)) u_wr (
    .clk_w   (clk_w),
    .rst     (rst_any),
    .we      (we),
    .rgray_s (rgray_s),
    .mem_we  (mem_we),
    .waddr   (waddr),
    .wbin    (wbin),
    .wgray   (wgray),
    .full    (no_room)
  );

  fifo_rd_ctrl #(.AW(AW), .RT_CYCLES(RT_CYCLES)) u_rd (
    .clk_r    (clk_r),
    .rst      (rst_any),
    .mrst     (mrst),
    .mode_sel (mode_sel),
    .re       (re),
    .retx     (retx),
    .wgray_s  (wgray_s),
    .mem_rd   (mem_rd),
    .raddr    (raddr),
    .rbin     (rbin),
    .rgray    (rgray),
    .no_data  (no_data),
    .fwft_on  (fwft_on),
    .rt_idle  (rt_idle)
  );

  fifo_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk (clk_r),
    .rst (rst_any),
    .d   (wgray),
    .q   (wgray_s)
  );

  fifo_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk (clk_w),
    .rst (rst_any),
    .d   (rgray),
    .q   (rgray_s)
  );

  fifo_dpram #(.DW(DW), .AW(AW)) u_mem (
    .clk_w (clk_w),
    .wen   (mem_we),
    .waddr (waddr),
    .wdata (din),
    .clk_r (clk_r),
    .rst   (rst_any),
    .ren   (mem_rd),
    .raddr (raddr),
    .rdata (dout)
  );
endmodule

// File: rtl/fifo_chk.sv
`timescale 1ns/1ps
module fifo_chk #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input logic          clk_w,
  input logic          clk_r,
  input logic          rst_any,
  input logic          we,
  input logic          re,
  input logic          retx,
  input logic          no_room,
  input logic          no_data,
  input logic [DW-1:0] dout,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic          fwft_on,
  input logic          rt_idle
);
  // R7: a write offered while full leaves the write pointer where it was
  a_r7_full_blocks_write: assert property (@(posedge clk_w) disable iff (rst_any)
    (no_room && we) |=> $stable(wbin));

  // R7: a standard-mode read offered while empty leaves the read pointer
  a_r7_empty_blocks_read: assert property (@(posedge clk_r) disable iff (rst_any)
    (!fwft_on && no_data && re && !retx) |=> $stable(rbin));

  // R8: an accepted rewind puts the read pointer on location zero and hides data
  a_r8_rewind_to_zero: assert property (@(posedge clk_r) disable iff (rst_any)
    (retx && rt_idle) |=> (rbin == '0) && no_data);

  // R8: data stays hidden on the edge after the rewind edge as well
  a_r8_setup_holds: assert property (@(posedge clk_r) disable iff (rst_any)
    (retx && rt_idle) |-> ##2 no_data);

  // R4: standard-mode output moves only with an accepted read
  a_r4_std_dout_hold: assert property (@(posedge clk_r) disable iff (rst_any)
    (!fwft_on && !(re && !no_data)) |=> $stable(dout));

  // R5: a valid fall-through word stays put until it is consumed
  a_r5_fwft_hold: assert property (@(posedge clk_r) disable iff (rst_any)
    (fwft_on && !no_data && !re && !retx) |=> (!no_data && $stable(dout)));
endmodule

bind fifo_top fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_w   (clk_w),
  .clk_r   (clk_r),
  .rst_any (rst_any),
  .we      (we),
  .re      (re),
  .retx    (retx),
  .no_room (no_room),
  .no_data (no_data),
  .dout    (dout),
  .wbin    (wbin),
  .rbin    (rbin),
  .fwft_on (fwft_on),
  .rt_idle (rt_idle)
);

// File: tb/tb_fifo_top.sv
`timescale 1ns/1ps
module tb_fifo_top;
  localparam int CLK_PERIOD  = 10;   // write clock
  localparam int RCLK_PERIOD = 14;   // read clock, edges on even ns, write edges on odd ns
  localparam int DW          = 9;
  localparam int DEPTH       = 16;
  localparam int WDOG_LIMIT  = 20000;

  typedef struct packed {
    logic       fwft;
    logic [4:0] n;
    logic [8:0] base;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{fwft: 1'b0, n: 5'd3,  base: 9'h005},
    '{fwft: 1'b1, n: 5'd3,  base: 9'h1F0},
    '{fwft: 1'b0, n: 5'd16, base: 9'h100},
    '{fwft: 1'b1, n: 5'd16, base: 9'h0AA},
    '{fwft: 1'b0, n: 5'd1,  base: 9'h1FF}
  };

  logic          clk_w = 1'b0, clk_r = 1'b0;
  logic          mrst = 1'b1, prst = 1'b0, mode_sel = 1'b0;
  logic          we = 1'b0, re = 1'b0, retx = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          no_data, no_room;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  fifo_top #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk_w (clk_w), .clk_r (clk_r), .mrst (mrst), .prst (prst),
    .mode_sel (mode_sel), .we (we), .din (din), .re (re), .retx (retx),
    .dout (dout), .no_data (no_data), .no_room (no_room)
  );

  initial forever #(CLK_PERIOD/2) clk_w = ~clk_w;
  initial begin
    #2;
    forever begin
      clk_r = 1'b1; #(RCLK_PERIOD/2);
      clk_r = 1'b0; #(RCLK_PERIOD/2);
    end
  end

  always @(posedge clk_r) begin
    cyc++;
    if (cyc > WDOG_LIMIT && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog (all requirements): cycles=%0d expected<=%0d", cyc, WDOG_LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_mreset(input logic m);
    @(negedge clk_r);
    mrst = 1'b1; mode_sel = m; we = 1'b0; re = 1'b0; retx = 1'b0; prst = 1'b0;
    repeat (3) @(posedge clk_r);
    @(negedge clk_r);
    mrst = 1'b0;
    repeat (2) @(posedge clk_r);
    #1;
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk_w);
    we = 1'b1; din = d;
    @(posedge clk_w);
    we <= 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk_r);
    re = 1'b1;
    @(posedge clk_r);
    re <= 1'b0;
    #1;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk_r);
    #1;
  endtask

  task automatic rewind_seq(input string req);
    @(negedge clk_r);
    retx = 1'b1;
    @(posedge clk_r);
    retx <= 1'b0;
    #1 chk({req, " no_data after rewind edge"}, 32'(no_data), 32'd1);
    @(posedge clk_r);
    #1 chk({req, " no_data one edge later"}, 32'(no_data), 32'd1);
    @(posedge clk_r);
    #1 chk({req, " no_data released second edge"}, 32'(no_data), 32'd0);
  endtask

  initial begin
    // R2: reset state
    do_mreset(1'b0);
    chk("R2 no_data after master reset", 32'(no_data), 32'd1);
    chk("R2 no_room after master reset", 32'(no_room), 32'd0);
    chk("R2 dout after master reset", 32'(dout), 32'd0);

    // Vector table: mode, word count, data base -> in-order readout
    for (int v = 0; v < NVEC; v++) begin
      do_mreset(VECS[v].fwft);
      for (int i = 0; i < int'(VECS[v].n); i++) wr(DW'(VECS[v].base + 9'(i)));
      settle();
      if (!VECS[v].fwft && int'(VECS[v].n) == DEPTH)
        chk("R7 no_room with DEPTH words", 32'(no_room), 32'd1);
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        if (VECS[v].fwft) begin
          chk("R5 fwft word valid", 32'(no_data), 32'd0);
          chk("R5 fwft word order", 32'(dout), 32'(DW'(VECS[v].base + 9'(i))));
          rd_pulse();
        end else begin
          chk("R4 standard data available", 32'(no_data), 32'd0);
          rd_pulse();
          chk("R4 standard word order", 32'(dout), 32'(DW'(VECS[v].base + 9'(i))));
        end
      end
      settle();
      chk("R4 R5 drained to no_data", 32'(no_data), 32'd1);
    end

    // R1 + R6: standard mode, mode_sel flipped after reset is ignored
    do_mreset(1'b0);
    mode_sel = 1'b1;
    @(negedge clk_w); we = 1'b1; din = 9'h0AB;
    @(posedge clk_w); we <= 1'b0;
    repeat (2) @(posedge clk_r);
    #1 chk("R6 no_data still set after two edges", 32'(no_data), 32'd1);
    @(posedge clk_r);
    #1 chk("R6 no_data falls on third edge", 32'(no_data), 32'd0);
    settle();
    chk("R1 no fall-through after mode_sel change", 32'(dout), 32'd0);
    rd_pulse();
    chk("R4 read after request", 32'(dout), 32'h0AB);

    // R2: master reset clears dout; R5 three-edge latency
    do_mreset(1'b1);
    chk("R2 dout cleared by master reset", 32'(dout), 32'd0);
    @(negedge clk_w); we = 1'b1; din = 9'h123;
    @(posedge clk_w); we <= 1'b0;
    repeat (2) @(posedge clk_r);
    #1 chk("R5 not valid after two edges", 32'(no_data), 32'd1);
    @(posedge clk_r);
    #1 chk("R5 valid on third edge", 32'(no_data), 32'd0);
    chk("R5 word on dout without re", 32'(dout), 32'h123);

    // R3: partial reset keeps fall-through mode
    @(negedge clk_r); mode_sel = 1'b0; prst = 1'b1;
    repeat (2) @(posedge clk_r);
    @(negedge clk_r); prst = 1'b0;
    repeat (2) @(posedge clk_r);
    #1;
    chk("R2 no_data after partial reset", 32'(no_data), 32'd1);
    chk("R2 dout after partial reset", 32'(dout), 32'd0);
    chk("R2 no_room after partial reset", 32'(no_room), 32'd0);
    wr(9'h066);
    settle();
    chk("R3 still fall-through after partial reset", 32'(dout), 32'h066);

    // R7: overflow and underflow are dropped
    do_mreset(1'b0);
    for (int i = 0; i < DEPTH; i++) wr(DW'(9'h040 + 9'(i)));
    @(negedge clk_w);
    chk("R7 no_room right after last write", 32'(no_room), 32'd1);
    wr(9'h0EE);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      rd_pulse();
      chk("R7 contents intact after dropped write", 32'(dout), 32'(DW'(9'h040 + 9'(i))));
    end
    chk("R7 empty after DEPTH reads", 32'(no_data), 32'd1);
    rd_pulse();
    chk("R7 read while empty dropped", 32'(dout), 32'h04F);
    settle();
    chk("R7 no_room cleared after reads", 32'(no_room), 32'd0);

    // R8: rewind in standard mode
    do_mreset(1'b0);
    for (int i = 0; i < 4; i++) wr(DW'(9'h0A0 + 9'(i)));
    settle();
    rd_pulse();
    rd_pulse();
    chk("R8 second word before rewind", 32'(dout), 32'h0A1);
    rewind_seq("R8");
    chk("R8 dout unchanged without re", 32'(dout), 32'h0A1);
    for (int i = 0; i < 4; i++) begin
      rd_pulse();
      chk("R8 reread from location zero", 32'(dout), 32'(DW'(9'h0A0 + 9'(i))));
    end

    // R9: rewind in fall-through mode
    do_mreset(1'b1);
    for (int i = 0; i < 3; i++) wr(DW'(9'h150 + 9'(i)));
    settle();
    rd_pulse();
    rd_pulse();
    chk("R9 third word before rewind", 32'(dout), 32'h152);
    rewind_seq("R9");
    chk("R9 location zero on dout at release", 32'(dout), 32'h150);
    rd_pulse();
    chk("R9 next word after rewind", 32'(dout), 32'h151);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule